// File: doc/BRIEF.md
# Recirculating Key-Memory Voice Assigner

This block turns the time-multiplexed output of a 64-slot keyboard scanner into two monophonic voices. The scanner presents one slot per clock: an active-low key bit, a flag marking the last slot of each scan, a flag that is high while the upper half of the keyboard is being scanned, and a flag that says whether the current scan may be interpreted. Each voice keeps one scan's worth of key states in a 64-bit serial register. That register rotates once per slot, so its output is a pulse that falls in the slot of the note it holds. A separate converter turns that pulse into a pitch voltage.

Each voice first builds a candidate frame from live key data, filtered by its own mode: monophonic, duophonic or split. At the scan boundary the voice either takes the whole candidate frame or keeps rotating its own contents. A scan with no key in range, or a scan that is not interpreted, leaves the stored note unchanged, so the pitch stays steady after release. Each voice also drives a gate that follows the most recent interpreted scan.

A scan-phase state machine shared by both voices has four states. SEEK follows reset and waits for the first scan boundary. FIRST is slot 0 of a scan, where the interpret flag is sampled. LIVE is the rest of an interpreted scan. RECIRC is the rest of a scan that is not interpreted. The transitions are: SEEK→FIRST on the boundary flag; FIRST→LIVE when the interpret flag is high; FIRST→RECIRC when it is low; LIVE→FIRST and RECIRC→FIRST on the boundary flag. Every other case holds the current state. A commit happens only on the boundary slot of an interpreted scan.

Top module: `voice_key_memory`

## Requirements
- R1: After reset, pitch_a, pitch_b, gate_a and gate_b are low. Key data in the scan that is in progress when reset is released is ignored up to the first slot with frame_mark high.
- R2: Mode encoding is 2'b00 mono, 2'b01 duo, 2'b10 split, and 2'b11 behaves as mono. In mono, each channel stores the lowest pressed slot over the whole keyboard.
- R3: In duo mode, channel A stores the lowest pressed slot and channel B stores the highest pressed slot.
- R4: In split mode, channel A responds only to slots where upper_half is low and channel B only to slots where upper_half is high. Each keeps the lowest pressed slot of its half and ignores keys of the other half.
- R5: On the frame_mark slot of an interpreted scan, gate goes high if a key in the channel's range was pressed during that scan and low otherwise. It holds its value between such slots.
- R6: An interpreted scan with no key in a channel's range leaves that channel's stored slot unchanged, so the pitch pulse continues after release.
- R7: A scan whose interp_scan is low in its first slot changes neither pitch nor gate, whatever keys are pressed.
- R8: The pitch output is high in exactly the stored slot of every scan. A new note replaces the old one only from slot 0 of the scan after the committing one, so a scan in progress still shows the old note.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per scanner slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n | input | 1 | Key data of the current slot, low when pressed |
| frame_mark | input | 1 | High in the last slot (63) of each scan |
| upper_half | input | 1 | High while slots 32..63 are scanned |
| interp_scan | input | 1 | High during scans whose key data may be loaded |
| mode_a | input | 2 | Mode of channel A (encoding in R2) |
| mode_b | input | 2 | Mode of channel B (encoding in R2) |
| pitch_a | output | 1 | Channel A pitch pulse, high in the stored slot |
| gate_a | output | 1 | Channel A gate |
| pitch_b | output | 1 | Channel B pitch pulse, high in the stored slot |
| gate_b | output | 1 | Channel B gate |

## Verification
The pitch pulse for slot s is due in the same cycle in which the scanner presents slot s. It reflects the frame committed at the end of the previous interpreted scan, so every pitch check falls one whole scan after the stimulus that caused it. The gate is due one cycle after the frame_mark slot. The bench therefore drives each slot on a falling edge, samples pitch 1 ns later before the rising edge, and samples the gates 1 ns after the rising edge that ends a scan. It compares against a model of the requirements that it updates only at scan boundaries.

// File: rtl/vkm_pkg.sv
package vkm_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        MODE_MONO  = 2'b00,
        MODE_DUO   = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_ALT   = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        PH_SEEK   = 2'b00,
        PH_FIRST  = 2'b01,
        PH_LIVE   = 2'b10,
        PH_RECIRC = 2'b11
    } scan_phase_e;

endpackage

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import vkm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_mark_i,
    input  logic interp_i,
    output logic collect_o,
    output logic commit_o,
    output logic clear_o
);

    scan_phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_SEEK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SEEK:   if (frame_mark_i) state_d = PH_FIRST;
            PH_FIRST:  if (frame_mark_i) state_d = PH_FIRST;
                       else if (interp_i) state_d = PH_LIVE;
                       else state_d = PH_RECIRC;
            PH_LIVE:   if (frame_mark_i) state_d = PH_FIRST;
            PH_RECIRC: if (frame_mark_i) state_d = PH_FIRST;
        endcase
    end

    // outputs
    always_comb begin
        collect_o = 1'b0;
        unique case (state_q)
            PH_SEEK:   collect_o = 1'b0;
            PH_FIRST:  collect_o = interp_i;
            PH_LIVE:   collect_o = 1'b1;
            PH_RECIRC: collect_o = 1'b0;
        endcase
        commit_o = collect_o && frame_mark_i;
        clear_o  = frame_mark_i;
    end

    assert_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark_i |=> (state_q == PH_FIRST));

    assert_skip_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RECIRC || state_q == PH_SEEK) |-> !commit_o);

endmodule

// File: rtl/key_channel.sv
module key_channel
    import vkm_pkg::*;
#(
    parameter int SLOTS    = 64,
    parameter bit UPPER_CH = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_hit_i,
    input  logic       upper_i,
    input  chan_mode_e mode_i,
    input  logic       collect_i,
    input  logic       commit_i,
    input  logic       clear_i,
    output logic       pitch_o,
    output logic       gate_o
);

    localparam logic [SLOTS-1:0] TOP_BIT = {1'b1, {(SLOTS-1){1'b0}}};

    logic [SLOTS-1:0] cand_q, cand_d, mem_q;
    logic             seen_q, seen_d;
    logic             in_range, take_high, hit;

    always_comb begin
        in_range  = 1'b1;
        take_high = 1'b0;
        unique case (mode_i)
            MODE_SPLIT: in_range  = (upper_i == UPPER_CH);
            MODE_DUO:   take_high = UPPER_CH;
            default:    in_range  = 1'b1;
        endcase
        hit    = collect_i && key_hit_i && in_range;
        seen_d = seen_q || hit;
        if (hit && take_high)
            cand_d = TOP_BIT;
        else if (hit && !seen_q)
            cand_d = {1'b1, cand_q[SLOTS-1:1]};
        else
            cand_d = {1'b0, cand_q[SLOTS-1:1]};
    end

    // candidate frame, rebuilt every scan
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
            seen_q <= 1'b0;
        end else if (clear_i) begin
            cand_q <= '0;
            seen_q <= 1'b0;
        end else begin
            cand_q <= cand_d;
            seen_q <= seen_d;
        end
    end

    // key memory: takes the candidate at a committing boundary, else rotates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q  <= '0;
            gate_o <= 1'b0;
        end else begin
            if (commit_i && seen_d) mem_q <= cand_d;
            else                    mem_q <= {mem_q[0], mem_q[SLOTS-1:1]};
            if (commit_i)           gate_o <= seen_d;
        end
    end

    assign pitch_o = mem_q[0];

    assert_one_note_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_q));

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(gate_o));

    assert_gate_has_note_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (mem_q != '0));

endmodule

// File: rtl/voice_key_memory.sv
module voice_key_memory
    import vkm_pkg::*;
#(
    parameter int SLOTS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_n,
    input  logic       frame_mark,
    input  logic       upper_half,
    input  logic       interp_scan,
    input  logic [1:0] mode_a,
    input  logic [1:0] mode_b,
    output logic       pitch_a,
    output logic       gate_a,
    output logic       pitch_b,
    output logic       gate_b
);

    logic collect, commit, clear;
    logic [NUM_CH-1:0] pitch_vec, gate_vec;
    chan_mode_e        mode_vec [NUM_CH];

    assign mode_vec[0] = chan_mode_e'(mode_a);
    assign mode_vec[1] = chan_mode_e'(mode_b);

    scan_phase_fsm u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_mark_i (frame_mark),
        .interp_i     (interp_scan),
        .collect_o    (collect),
        .commit_o     (commit),
        .clear_o      (clear)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        key_channel #(
            .SLOTS    (SLOTS),
            .UPPER_CH (c == 1)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .key_hit_i (!key_n),
            .upper_i   (upper_half),
            .mode_i    (mode_vec[c]),
            .collect_i (collect),
            .commit_i  (commit),
            .clear_i   (clear),
            .pitch_o   (pitch_vec[c]),
            .gate_o    (gate_vec[c])
        );
    end

    assign pitch_a = pitch_vec[0];
    assign pitch_b = pitch_vec[1];
    assign gate_a  = gate_vec[0];
    assign gate_b  = gate_vec[1];

endmodule

// File: tb/voice_key_memory_bench.sv
`timescale 1ns/1ps
module voice_key_memory_bench;

    logic clk = 1'b0;
    logic rst_n, key_n, frame_mark, upper_half, interp_scan;
    logic [1:0] mode_a, mode_b;
    logic pitch_a, gate_a, pitch_b, gate_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] exp_pa = '0, exp_pb = '0;
    logic        exp_ga = 1'b0, exp_gb = 1'b0;
    bit          synced = 0;
    string       shown_tag = "R1";

    always #10 clk = ~clk;

    voice_key_memory u_voice_key_memory (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .frame_mark(frame_mark),
        .upper_half(upper_half), .interp_scan(interp_scan),
        .mode_a(mode_a), .mode_b(mode_b),
        .pitch_a(pitch_a), .gate_a(gate_a), .pitch_b(pitch_b), .gate_b(gate_b)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    function automatic logic [63:0] pick(input logic [63:0] keys, input int lo,
                                         input int hi, input bit high);
        logic [63:0] r = '0;
        for (int s = lo; s <= hi; s++)
            if (keys[s] && (high || r == '0)) r = 64'd1 << s;
        return r;
    endfunction

    // one full scan; pitch checked every slot, gates after the boundary edge
    task automatic run_frame(input logic [63:0] keys, input logic interp, input string tag);
        int bad_a = 0, bad_b = 0;
        logic [63:0] na, nb;
        bit split_a, split_b;
        for (int s = 0; s < 64; s++) begin
            @(negedge clk);
            key_n       = !keys[s];
            upper_half  = (s >= 32);
            frame_mark  = (s == 63);
            interp_scan = interp;
            #1;
            if (pitch_a !== exp_pa[s]) bad_a++;
            if (pitch_b !== exp_pb[s]) bad_b++;
        end
        check(bad_a, 0, {shown_tag, "/R8 pitch_a wrong slots during ", tag, " scan"});
        check(bad_b, 0, {shown_tag, "/R8 pitch_b wrong slots during ", tag, " scan"});
        // model update from requirements
        if (!synced) begin
            synced = 1;
        end else if (interp) begin
            split_a = (mode_a == 2'b10);
            split_b = (mode_b == 2'b10);
            na = pick(keys, 0, split_a ? 31 : 63, 1'b0);
            nb = pick(keys, split_b ? 32 : 0, 63, mode_b == 2'b01);
            if (na != '0) exp_pa = na;
            if (nb != '0) exp_pb = nb;
            exp_ga = (na != '0);
            exp_gb = (nb != '0);
        end
        shown_tag = tag;
        @(posedge clk); #1;
        check(gate_a, exp_ga, {tag, "/R5 gate_a after scan"});
        check(gate_b, exp_gb, {tag, "/R5 gate_b after scan"});
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0; key_n = 1'b1; frame_mark = 1'b0; upper_half = 1'b0;
        interp_scan = 1'b0; mode_a = 2'b00; mode_b = 2'b00;
        repeat (3) @(negedge clk);
        check(pitch_a, 0, "R1 pitch_a in reset");
        check(gate_a,  0, "R1 gate_a in reset");
        check(pitch_b, 0, "R1 pitch_b in reset");
        check(gate_b,  0, "R1 gate_b in reset");
        rst_n = 1'b1;
        run_frame((64'd1 << 10), 1'b1, "R1");
    endtask

    task automatic t_mono_R2();
        mode_a = 2'b00; mode_b = 2'b00;
        run_frame((64'd1 << 10) | (64'd1 << 20) | (64'd1 << 40), 1'b1, "R2");
    endtask

    task automatic t_duo_R3();
        mode_a = 2'b01; mode_b = 2'b01;
        run_frame((64'd1 << 12) | (64'd1 << 30) | (64'd1 << 50), 1'b1, "R3");
    endtask

    task automatic t_split_R4();
        mode_a = 2'b10; mode_b = 2'b10;
        run_frame((64'd1 << 15) | (64'd1 << 25) | (64'd1 << 35) | (64'd1 << 45), 1'b1, "R4");
        run_frame((64'd1 << 5), 1'b1, "R4/R6 lower-only");
    endtask

    task automatic t_release_R6();
        run_frame('0, 1'b1, "R6");
    endtask

    task automatic t_skip_R7();
        mode_a = 2'b00; mode_b = 2'b00;
        run_frame((64'd1 << 3) | (64'd1 << 60), 1'b0, "R7");
    endtask

    task automatic t_alt_mode_R2();
        mode_a = 2'b11; mode_b = 2'b11;
        run_frame((64'd1 << 9) | (64'd1 << 60), 1'b1, "R2 alt-mode");
        mode_a = 2'b01; mode_b = 2'b01;
        run_frame('0, 1'b0, "R7 replay");
        run_frame((64'd1 << 2), 1'b0, "R8 replay");
    endtask

    initial begin
        t_reset_R1();
        t_mono_R2();
        t_duo_R3();
        t_split_R4();
        t_release_R6();
        t_skip_R7();
        t_alt_mode_R2();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule